// File: doc/BRIEF.md
# Multi-Entry Slave Address Matcher

This block sits beside the receive shift register of a two-wire serial slave. It compares the address byte(s) that follow a START or repeated START with three programmable entries. It then reports whether the device was addressed, which entry hit, and the transfer direction. Each entry holds a 7-bit address in bits 7..1 and a direction qualifier in bit 0. A separate low-address byte per entry completes a 10-bit address.

In 7-bit mode only the address field of an entry takes part in the comparison, and the received bit 0 gives the direction. In 10-bit mode the first header byte is compared with all eight bits of the entry. A header ending in 0 arms a second comparison against the entry's low byte. Before a repeated START, software can set bit 0 of an entry to 1. A read header (ending in 1) then matches that entry at once.

A STOP wipes bit 0 of every entry, so the read qualifier lasts for one transaction only. Bus bit timing, acknowledge generation and the shift register are handled by neighbouring blocks.

Top module: `addr_match_top`

## Requirements
- R1: After reset `match`, `match_idx` and `dir_read` are 0, and all entry and low-address bytes are 0.
- R2: Only the first byte after a START or repeated START is compared (in 10-bit mode, also the second byte after a header hit). Later bytes leave `match`, `match_idx` and `dir_read` unchanged until the next START, repeated START or STOP.
- R3: In 7-bit mode (`ten_bit_mode`=0) received bits 7..1 are compared with entry bits 7..1, and entry bit 0 is ignored. On a hit `dir_read` equals received bit 0.
- R4: When several entries hit, `match_idx` reports the lowest-numbered one (entry 0 before 1 before 2).
- R5: In 10-bit mode the first byte is compared with all 8 entry bits. A hit with received bit 0 = 0 does not yet raise `match`.
- R6: In 10-bit mode the byte after such a header is compared with the low-address byte of the entries whose header hit. On a hit `match`=1, `match_idx` is the lowest such entry, and `dir_read`=0. On a miss `match` stays 0.
- R7: In 10-bit mode a first byte with bit 0 = 1 that equals an entry whose bit 0 is 1 raises `match` at once, with `dir_read`=1.
- R8: A STOP clears bit 0 of every entry and keeps bits 7..1.
- R9: START, repeated START and STOP each clear `match`, `match_idx` and `dir_read` on the next clock.
- R10: A write with `cfg_lo`=0 loads `cfg_data` into entry `cfg_sel`, and `cfg_lo`=1 loads its low-address byte. If STOP occurs in the same cycle, bit 0 of the written entry is stored as 0 and bits 7..1 as written.
- R11: STOP takes priority over START or repeated START in the same cycle. Any of the three strobes takes priority over a byte strobe in the same cycle, and that byte is ignored.
- R12: Results are registered: a byte strobe sampled at one rising edge is reflected on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| byte_vld | input | 1 | One-cycle strobe: a received byte is complete |
| byte_data | input | 8 | Received byte, bit 0 last on the wire |
| start_det | input | 1 | START detected strobe |
| rstart_det | input | 1 | Repeated START detected strobe |
| stop_det | input | 1 | STOP detected strobe |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| cfg_we | input | 1 | Entry write strobe |
| cfg_lo | input | 1 | 0 writes the entry byte, 1 the low-address byte |
| cfg_sel | input | 2 | Entry number; values of 3 and above are ignored |
| cfg_data | input | 8 | Write data |
| match | output | 1 | Device addressed in the current transaction |
| match_idx | output | 2 | Winning entry number |
| dir_read | output | 1 | 1 = master reads, valid with `match` |

## Verification
Some properties are checked on every cycle. The strobes clear the flag on the next edge, and `match` only rises on a byte strobe. A raised flag keeps its index and direction until a strobe arrives. The index stays in range, and every bit 0 of an entry is zero after a STOP. The bench's scenarios show the comparison itself. In 7-bit mode all 256 byte values are swept against overlapping entries. In 10-bit mode every header is tried against four low bytes. The bench also covers the read-qualifier sequence across a repeated START, the STOP/write collision, and the same-cycle priority cases.

// File: rtl/sam_pkg.sv
package sam_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_HEADER = 2'd1,
    PH_LOW    = 2'd2,
    PH_DONE   = 2'd3
  } phase_e;
endpackage

// File: rtl/sam_prio.sv
module sam_prio #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/sam_entry_bank.sv
module sam_entry_bank
  import sam_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_lo,
  input  logic [IW-1:0]          cfg_sel,
  input  logic [BYTE_W-1:0]      cfg_data,
  input  logic                   stop_det,
  output logic [N-1:0][BYTE_W-1:0] ent,
  output logic [N-1:0][BYTE_W-1:0] low,
  output logic [N-1:0]           rw_bits
);
  logic [N-1:0][BYTE_W-1:0] ent_q, ent_d;
  logic [N-1:0][BYTE_W-1:0] low_q, low_d;
  logic [N-1:0]             ent_en, low_en;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic sel_hit;
    assign sel_hit   = cfg_we && (cfg_sel == IW'(g));
    assign ent_en[g] = (sel_hit && !cfg_lo) || stop_det;
    assign low_en[g] = sel_hit && cfg_lo;

    always_comb begin
      ent_d[g] = ent_q[g];
      low_d[g] = low_q[g];
      if (sel_hit && !cfg_lo) ent_d[g] = cfg_data;
      if (sel_hit && cfg_lo)  low_d[g] = cfg_data;
      if (stop_det)           ent_d[g][0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
        low_q[g] <= '0;
      end else begin
        if (ent_en[g]) ent_q[g] <= ent_d[g];
        if (low_en[g]) low_q[g] <= low_d[g];
      end
    end

    assign rw_bits[g] = ent_q[g][0];
  end

  assign ent = ent_q;
  assign low = low_q;
endmodule

// File: rtl/sam_compare.sv
module sam_compare
  import sam_pkg::*;
#(
  parameter int N = 3
) (
  input  logic [BYTE_W-1:0]        rx_byte,
  input  logic [N-1:0][BYTE_W-1:0] ent,
  input  logic [N-1:0][BYTE_W-1:0] low,
  input  logic [N-1:0]             cand,
  input  logic                     ten_bit,
  output logic [N-1:0]             hdr_hit,
  output logic [N-1:0]             low_hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic addr_eq, full_eq;
    assign addr_eq    = rx_byte[BYTE_W-1:1] == ent[g][BYTE_W-1:1];
    assign full_eq    = addr_eq && (rx_byte[0] == ent[g][0]);
    assign hdr_hit[g] = ten_bit ? full_eq : addr_eq;
    assign low_hit[g] = cand[g] && (rx_byte == low[g]);
  end
endmodule

// File: rtl/sam_seq.sv
module sam_seq
  import sam_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_det,
  input  logic          rstart_det,
  input  logic          stop_det,
  input  logic          byte_vld,
  input  logic          rx_lsb,
  input  logic          ten_bit,
  input  logic [N-1:0]  hdr_hit,
  input  logic          hdr_any,
  input  logic [IW-1:0] hdr_idx,
  input  logic          low_any,
  input  logic [IW-1:0] low_idx,
  output logic [N-1:0]  cand,
  output logic          match,
  output logic [IW-1:0] match_idx,
  output logic          dir_read
);
  phase_e        ph_q, ph_d;
  logic [N-1:0]  cand_d;
  logic          match_d, dir_d;
  logic [IW-1:0] idx_d;
  logic          upd_en;

  assign upd_en = stop_det || start_det || rstart_det || byte_vld;

  always_comb begin
    ph_d    = ph_q;
    cand_d  = cand;
    match_d = match;
    idx_d   = match_idx;
    dir_d   = dir_read;
    if (stop_det) begin
      ph_d    = PH_IDLE;
      cand_d  = '0;
      match_d = 1'b0;
      idx_d   = '0;
      dir_d   = 1'b0;
    end else if (start_det || rstart_det) begin
      ph_d    = PH_HEADER;
      cand_d  = '0;
      match_d = 1'b0;
      idx_d   = '0;
      dir_d   = 1'b0;
    end else if (byte_vld) begin
      unique case (ph_q)
        PH_HEADER: begin
          ph_d = PH_DONE;
          if (hdr_any) begin
            if (!ten_bit || rx_lsb) begin
              match_d = 1'b1;
              idx_d   = hdr_idx;
              dir_d   = rx_lsb;
            end else begin
              ph_d   = PH_LOW;
              cand_d = hdr_hit;
            end
          end
        end
        PH_LOW: begin
          ph_d   = PH_DONE;
          cand_d = '0;
          if (low_any) begin
            match_d = 1'b1;
            idx_d   = low_idx;
            dir_d   = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cand      <= '0;
      match     <= 1'b0;
      match_idx <= '0;
      dir_read  <= 1'b0;
    end else if (upd_en) begin
      ph_q      <= ph_d;
      cand      <= cand_d;
      match     <= match_d;
      match_idx <= idx_d;
      dir_read  <= dir_d;
    end
  end
endmodule

// File: rtl/addr_match_top.sv
module addr_match_top
  import sam_pkg::*;
#(
  parameter int NUM_ENTRIES = 3,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              start_det,
  input  logic              rstart_det,
  input  logic              stop_det,
  input  logic              ten_bit_mode,
  input  logic              cfg_we,
  input  logic              cfg_lo,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [BYTE_W-1:0] cfg_data,
  output logic              match,
  output logic [IDX_W-1:0]  match_idx,
  output logic              dir_read
);
  logic [NUM_ENTRIES-1:0][BYTE_W-1:0] ent, low;
  logic [NUM_ENTRIES-1:0]             rw_bits, cand, hdr_hit, low_hit;
  logic                               hdr_any, low_any;
  logic [IDX_W-1:0]                   hdr_idx, low_idx;

  sam_entry_bank #(.N(NUM_ENTRIES), .IW(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lo(cfg_lo),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .stop_det(stop_det),
    .ent(ent), .low(low), .rw_bits(rw_bits)
  );

  sam_compare #(.N(NUM_ENTRIES)) u_cmp (
    .rx_byte(byte_data), .ent(ent), .low(low), .cand(cand),
    .ten_bit(ten_bit_mode), .hdr_hit(hdr_hit), .low_hit(low_hit)
  );

  sam_prio #(.N(NUM_ENTRIES), .IW(IDX_W)) u_prio_hdr (
    .req(hdr_hit), .any(hdr_any), .idx(hdr_idx)
  );

  sam_prio #(.N(NUM_ENTRIES), .IW(IDX_W)) u_prio_low (
    .req(low_hit), .any(low_any), .idx(low_idx)
  );

  sam_seq #(.N(NUM_ENTRIES), .IW(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .rstart_det(rstart_det),
    .stop_det(stop_det), .byte_vld(byte_vld), .rx_lsb(byte_data[0]),
    .ten_bit(ten_bit_mode), .hdr_hit(hdr_hit), .hdr_any(hdr_any),
    .hdr_idx(hdr_idx), .low_any(low_any), .low_idx(low_idx), .cand(cand),
    .match(match), .match_idx(match_idx), .dir_read(dir_read)
  );
endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_vld,
  input logic          start_det,
  input logic          rstart_det,
  input logic          stop_det,
  input logic          match,
  input logic [IW-1:0] match_idx,
  input logic          dir_read,
  input logic [N-1:0]  rw_bits
);
  logic ctrl;
  assign ctrl = start_det || rstart_det || stop_det;

  a_r9_clear_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl |=> !match && !dir_read && (match_idx == '0));

  a_r8_stop_clears_rw: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (rw_bits == '0));

  a_r2_hold_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !ctrl) |=> match && $stable(match_idx) && $stable(dir_read));

  a_r12_rise_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && !byte_vld) |=> !match);

  a_r11_ctrl_beats_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl && byte_vld) |=> !match);

  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (match_idx <= IW'(N - 1)));

  a_r3_dir_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    !match |-> !dir_read);
endmodule

bind addr_match_top sam_checker #(.N(NUM_ENTRIES), .IW(IDX_W)) u_sam_checker (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .start_det(start_det),
  .rstart_det(rstart_det), .stop_det(stop_det), .match(match),
  .match_idx(match_idx), .dir_read(dir_read), .rw_bits(rw_bits)
);

// File: tb/test_addr_match_top.sv
module test_addr_match_top;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       byte_vld, start_det, rstart_det, stop_det, ten_bit_mode;
  logic       cfg_we, cfg_lo;
  logic [1:0] cfg_sel;
  logic [7:0] byte_data, cfg_data;
  logic       match, dir_read;
  logic [1:0] match_idx;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_ent [3];
  logic [7:0] m_low [3];

  addr_match_top i_addr_match_top (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .start_det(start_det), .rstart_det(rstart_det), .stop_det(stop_det),
    .ten_bit_mode(ten_bit_mode), .cfg_we(cfg_we), .cfg_lo(cfg_lo),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .match(match),
    .match_idx(match_idx), .dir_read(dir_read)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [3:0] obs();
    return {match, match_idx, dir_read};
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {match,idx,dir} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle_all();
    byte_vld = 0; start_det = 0; rstart_det = 0; stop_det = 0;
    cfg_we = 0; cfg_lo = 0; cfg_sel = 0; cfg_data = 0; byte_data = 0;
  endtask

  // one cycle of stimulus, applied at a falling edge, removed at the next
  task automatic cyc(input logic s, input logic r, input logic p,
                     input logic bv, input logic [7:0] bd);
    @(negedge clk);
    start_det = s; rstart_det = r; stop_det = p; byte_vld = bv; byte_data = bd;
    @(negedge clk);
    idle_all();
  endtask

  task automatic wr(input logic [1:0] sel, input logic lo, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_lo = lo; cfg_data = d;
    @(negedge clk);
    idle_all();
    if (lo) m_low[sel] = d; else m_ent[sel] = d;
  endtask

  function automatic logic [3:0] exp7(input logic [7:0] b);
    for (int i = 0; i < 3; i++)
      if (m_ent[i][7:1] == b[7:1]) return {1'b1, 2'(i), b[0]};
    return 4'b0;
  endfunction

  function automatic logic [3:0] exp10(input logic [7:0] h, input logic [7:0] s);
    for (int i = 0; i < 3; i++)
      if (m_ent[i] == h && m_low[i] == s) return {1'b1, 2'(i), 1'b0};
    return 4'b0;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_all();
    ten_bit_mode = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", obs(), 4'b0);
    for (int i = 0; i < 3; i++) begin m_ent[i] = 8'h00; m_low[i] = 8'h00; end
    // R1: entries are zero after reset -> address 0 header hits entry 0
    cyc(1, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'h01);
    chk("R1 reset entry contents", obs(), 4'b1001);

    // R3/R4: 7-bit sweep; entries 0 and 1 share address 0x2A, differ in bit 0
    wr(0, 0, 8'h54); wr(1, 0, 8'h55); wr(2, 0, 8'h3F);
    for (int b = 0; b < 256; b++) begin
      cyc(1, 0, 0, 0, 8'h00);
      cyc(0, 0, 0, 1, 8'(b));
      chk("R3 R4 seven-bit sweep", obs(), exp7(8'(b)));
    end
    // R4: entry 1 wins when entry 0 no longer covers the address
    wr(0, 0, 8'h10);
    cyc(0, 1, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'h55);
    chk("R4 next lowest entry", obs(), 4'b1011);

    // R2: later bytes ignored after a hit and after a miss
    cyc(0, 0, 0, 1, 8'h3F);
    chk("R2 later byte after hit", obs(), 4'b1011);
    cyc(1, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'hAA);
    cyc(0, 0, 0, 1, 8'h3E);
    chk("R2 later byte after miss", obs(), 4'b0000);

    // R9: clear strobes
    cyc(1, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'h3E);
    chk("R9 setup hit", obs(), 4'b1100);
    cyc(0, 1, 0, 0, 8'h00);
    chk("R9 repeated start clears", obs(), 4'b0000);
    cyc(0, 0, 0, 1, 8'h3F);
    cyc(0, 0, 1, 0, 8'h00);
    chk("R9 stop clears", obs(), 4'b0000);
    cyc(0, 0, 0, 1, 8'h3F);
    chk("R9 R2 no compare after stop", obs(), 4'b0000);

    // R11: priority in the same cycle
    cyc(1, 0, 0, 1, 8'h3E);
    chk("R11 byte with start ignored", obs(), 4'b0000);
    cyc(0, 0, 0, 1, 8'h3E);
    chk("R11 header still armed", obs(), 4'b1100);
    cyc(1, 0, 1, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'h3E);
    chk("R11 stop beats start", obs(), 4'b0000);

    // R5/R6/R4: 10-bit sweep over headers and four low bytes
    ten_bit_mode = 1;
    wr(0, 0, 8'hF0); wr(1, 0, 8'hF0); wr(2, 0, 8'hF2);
    wr(0, 1, 8'h11); wr(1, 1, 8'h22); wr(2, 1, 8'h11);
    for (int h = 0; h < 256; h++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] s;
        s = (k == 3) ? 8'hFF : m_low[k];
        cyc(1, 0, 0, 0, 8'h00);
        cyc(0, 0, 0, 1, 8'(h));
        if (k == 0) chk("R5 header alone no match", obs(), 4'b0000);
        cyc(0, 0, 0, 1, s);
        chk("R6 R4 ten-bit sweep", obs(), exp10(8'(h), s));
      end
    end

    // R7: read qualifier across repeated start
    cyc(1, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'hF0);
    cyc(0, 0, 0, 1, 8'h22);
    chk("R7 setup write match", obs(), 4'b1010);
    wr(1, 0, 8'hF1);
    cyc(0, 1, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'hF1);
    chk("R7 read header matches", obs(), 4'b1011);

    // R8: stop clears the qualifier, address kept
    cyc(0, 0, 1, 0, 8'h00);
    m_ent[1] = 8'hF0;
    cyc(1, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'hF1);
    chk("R8 qualifier gone after stop", obs(), 4'b0000);
    wr(0, 0, 8'h80);
    cyc(1, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'hF0);
    cyc(0, 0, 0, 1, 8'h22);
    chk("R8 address kept", obs(), 4'b1010);

    // R10: write colliding with stop
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2; cfg_lo = 0; cfg_data = 8'hF5; stop_det = 1;
    @(negedge clk);
    idle_all();
    m_ent[2] = 8'hF4;
    cyc(1, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'hF5);
    chk("R10 bit0 cleared by stop", obs(), 4'b0000);
    cyc(1, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'hF4);
    cyc(0, 0, 0, 1, 8'h11);
    chk("R10 address bits written", obs(), 4'b1100);
    // R10: out-of-range select ignored
    wr(3, 1, 8'h33);
    m_low[3 % 3] = m_low[0];
    cyc(1, 0, 0, 0, 8'h00);
    cyc(0, 0, 0, 1, 8'hF4);
    cyc(0, 0, 0, 1, 8'h11);
    chk("R10 select 3 ignored", obs(), 4'b1100);

    // R12: output visible right after the strobe edge, not before
    cyc(1, 0, 0, 0, 8'h00);
    @(negedge clk);
    byte_vld = 1; byte_data = 8'hF4;
    @(posedge clk);
    #1;
    chk("R12 header registered", obs(), 4'b0000);
    @(negedge clk);
    byte_data = 8'h11;
    chk("R12 no early match", obs(), 4'b0000);
    @(negedge clk);
    idle_all();
    chk("R12 match after edge", obs(), 4'b1100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule